// File: doc/BRIEF.md
# Serial-bus paged EEPROM slave

This block is a byte-addressed non-volatile memory front end that answers on a two-wire serial bus as a slave. It holds 2048 bytes, seen as eight banks of 256. It samples SCL and SDA with a fast system clock and rejects short spikes on both lines. It recognises START and STOP conditions and pulls SDA low to acknowledge or to return read data. The three bank bits travel in the device address byte. The second byte of a write sets the low eight bits of the word pointer.

Write data goes into a 32-byte staging buffer. The commit starts at the STOP and runs as a self-timed busy period. While the commit runs, the device ignores its own address, so a master learns that the write has finished by polling until it sees an acknowledge. If the write-protect input is high when the STOP arrives, the staged bytes are dropped. Reads return bytes from the pointer and advance it after each byte sent.

Top module: `i2c_eeprom`

## Requirements
- R1: An address byte whose upper nibble is 1010 (bit 0 = 1 for read, 0 for write) gets an acknowledge (SDA low on the ninth clock) when the device is idle. Any other upper nibble gets no acknowledge, and the rest of the transfer is ignored.
- R2: Address bits 3..1 become array address bits 10..8. The byte after a write address sets array address bits 7..0.
- R3: Each byte sent on a read advances the 11-bit pointer by one, carrying across bank boundaries.
- R4: Data bytes of one write fill the staging buffer. The low five pointer bits wrap inside the 32-byte page, and bits 10..5 do not change.
- R5: A STOP after at least one data byte commits the staged bytes. A repeated START discards them, so the array keeps its contents and no busy period follows.
- R6: If wp_i is high when the STOP arrives, no array byte changes and no busy period follows.
- R7: For WR_CYC clock cycles after a commit starts, the device address gets no acknowledge. After that it is acknowledged again.
- R8: A master NACK ends a read. The pointer then holds the start address plus the number of bytes sent, and the next read continues from there.
- R9: Pulses on SCL or SDA shorter than FILT_CYC clock cycles have no effect on the transfer.
- R10: After reset the device is idle, not busy, and releases SDA.
- R11: The device changes its SDA drive only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND) |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| wp_i | input | 1 | Write protect; 1 blocks the commit |

## Verification
The case hardest to reach from the pins is an address byte that arrives while a commit is running. The bench polls right after the STOP of a page write, expects no acknowledge, then waits out the busy period and polls again. It also reaches the case where the page wraps by starting a write two bytes before the page end. Spikes are injected mid-bit on SCL and on SDA during live address bytes, and the transfer must still complete normally.

// File: rtl/i2ce_pkg.sv
package i2ce_pkg;
  localparam int BLK_W   = 3;
  localparam int MEM_AW  = BLK_W + 8;
  localparam int MEM_DEP = 1 << MEM_AW;
  localparam int PAGE_AW = 5;
  localparam int PAGE    = 1 << PAGE_AW;
  localparam int UP_W    = MEM_AW - PAGE_AW;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_TACK} bus_st_t;
  typedef enum logic [1:0] {K_ADDR, K_WADDR, K_WDATA} rx_kind_t;
endpackage

// File: rtl/i2ce_filt.sv
module i2ce_filt #(
  parameter int CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(CYC + 1);

  logic          s1, s2, q, q_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    q_n   = q;
    cnt_n = '0;
    if (s2 != q) begin
      if (cnt == CW'(CYC - 1)) q_n = s2;
      else                     cnt_n = cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= 1'b1;
      s2  <= 1'b1;
      q   <= 1'b1;
      cnt <= '0;
    end else begin
      s1  <= din;
      s2  <= s1;
      q   <= q_n;
      cnt <= cnt_n;
    end
  end

  assign dout = q;
endmodule

// File: rtl/i2ce_bus.sv
module i2ce_bus
  import i2ce_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              busy,
  input  logic [7:0]        rd_dat,
  output logic              sda_pull,
  output logic [MEM_AW-1:0] ptr,
  output logic              pb_we,
  output logic [7:0]        pb_dat,
  output logic              cm_go,
  output logic              cm_drop,
  output bus_st_t           st_o,
  output rx_kind_t          kind_o
);
  bus_st_t           st, st_n;
  rx_kind_t          kind, kind_n;
  logic [3:0]        cnt, cnt_n;
  logic [7:0]        sreg, sreg_n;
  logic [MEM_AW-1:0] ptr_n;
  logic              sdl_n, rw, rw_n, mack, mack_n, have, have_n;
  logic              scl_q, sda_q;
  logic              rise, fall, start_c, stop_c;

  assign rise    = scl_f & ~scl_q;
  assign fall    = ~scl_f & scl_q;
  assign start_c = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c  = scl_f & scl_q & ~sda_q & sda_f;

  always_comb begin
    st_n    = st;
    kind_n  = kind;
    cnt_n   = cnt;
    sreg_n  = sreg;
    sdl_n   = sda_pull;
    ptr_n   = ptr;
    rw_n    = rw;
    mack_n  = mack;
    have_n  = have;
    pb_we   = 1'b0;
    pb_dat  = sreg;
    cm_go   = 1'b0;
    cm_drop = 1'b0;
    if (start_c) begin
      st_n    = S_RX;
      kind_n  = K_ADDR;
      cnt_n   = '0;
      sdl_n   = 1'b0;
      have_n  = 1'b0;
      cm_drop = 1'b1;
    end else if (stop_c) begin
      st_n   = S_IDLE;
      sdl_n  = 1'b0;
      have_n = 1'b0;
      cm_go  = have;
    end else begin
      case (st)
        S_RX: begin
          if (rise) begin
            sreg_n = {sreg[6:0], sda_f};
            cnt_n  = cnt + 4'd1;
          end else if (fall && cnt == 4'd8) begin
            cnt_n = '0;
            case (kind)
              K_ADDR: begin
                if (sreg[7:4] == DEV_ID && !busy) begin
                  ptr_n[MEM_AW-1 -: BLK_W] = sreg[BLK_W:1];
                  rw_n  = sreg[0];
                  sdl_n = 1'b1;
                  st_n  = S_ACK;
                end else begin
                  st_n = S_IDLE;
                end
              end
              K_WADDR: begin
                ptr_n[7:0] = sreg;
                sdl_n      = 1'b1;
                st_n       = S_ACK;
              end
              default: begin
                pb_we                = 1'b1;
                ptr_n[PAGE_AW-1:0]   = ptr[PAGE_AW-1:0] + PAGE_AW'(1);
                have_n               = 1'b1;
                sdl_n                = 1'b1;
                st_n                 = S_ACK;
              end
            endcase
          end
        end
        S_ACK: begin
          if (fall) begin
            sdl_n = 1'b0;
            cnt_n = '0;
            if (kind == K_ADDR && rw) begin
              st_n   = S_TX;
              sreg_n = rd_dat;
              sdl_n  = ~rd_dat[7];
            end else begin
              st_n   = S_RX;
              kind_n = (kind == K_ADDR) ? K_WADDR : K_WDATA;
            end
          end
        end
        S_TX: begin
          if (fall) begin
            if (cnt == 4'd7) begin
              st_n  = S_TACK;
              sdl_n = 1'b0;
              ptr_n = ptr + MEM_AW'(1);
              cnt_n = '0;
            end else begin
              cnt_n  = cnt + 4'd1;
              sreg_n = {sreg[6:0], 1'b0};
              sdl_n  = ~sreg[6];
            end
          end
        end
        S_TACK: begin
          if (rise) begin
            mack_n = ~sda_f;
          end else if (fall) begin
            if (mack) begin
              st_n   = S_TX;
              sreg_n = rd_dat;
              sdl_n  = ~rd_dat[7];
            end else begin
              st_n = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind     <= K_ADDR;
      cnt      <= '0;
      sreg     <= '0;
      sda_pull <= 1'b0;
      ptr      <= '0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      have     <= 1'b0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      st       <= st_n;
      kind     <= kind_n;
      cnt      <= cnt_n;
      sreg     <= sreg_n;
      sda_pull <= sdl_n;
      ptr      <= ptr_n;
      rw       <= rw_n;
      mack     <= mack_n;
      have     <= have_n;
      scl_q    <= scl_f;
      sda_q    <= sda_f;
    end
  end

  assign st_o   = st;
  assign kind_o = kind;
endmodule

// File: rtl/i2ce_commit.sv
module i2ce_commit
  import i2ce_pkg::*;
#(
  parameter int WR_CYC = 2500000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pb_we,
  input  logic [PAGE_AW-1:0] pb_idx,
  input  logic [7:0]         pb_dat,
  input  logic               cm_go,
  input  logic               cm_drop,
  input  logic [UP_W-1:0]    page,
  input  logic               wp,
  output logic               busy,
  output logic               mem_we,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [7:0]         mem_dat
);
  localparam int TW = $clog2(WR_CYC + 1);

  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] vld, vld_n;
  logic            busy_n;
  logic [TW-1:0]   tmr, tmr_n;
  logic [UP_W-1:0] base, base_n;
  logic [PAGE_AW-1:0] widx;

  assign widx = tmr[PAGE_AW-1:0];

  always_comb begin
    busy_n = busy;
    tmr_n  = tmr;
    base_n = base;
    vld_n  = vld;
    if (busy) begin
      if (tmr == TW'(WR_CYC - 1)) begin
        busy_n = 1'b0;
        vld_n  = '0;
      end else begin
        tmr_n = tmr + TW'(1);
      end
    end else if (cm_go) begin
      if (wp) begin
        vld_n = '0;
      end else begin
        busy_n = 1'b1;
        tmr_n  = '0;
        base_n = page;
      end
    end else if (cm_drop) begin
      vld_n = '0;
    end else if (pb_we) begin
      vld_n[pb_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tmr  <= '0;
      base <= '0;
      vld  <= '0;
    end else begin
      busy <= busy_n;
      tmr  <= tmr_n;
      base <= base_n;
      vld  <= vld_n;
    end
  end

  always_ff @(posedge clk) begin
    if (pb_we) pbuf[pb_idx] <= pb_dat;
  end

  assign mem_we   = busy && (tmr < TW'(PAGE)) && vld[widx];
  assign mem_addr = {base, widx};
  assign mem_dat  = pbuf[widx];
endmodule

// File: rtl/i2ce_array.sv
module i2ce_array
  import i2ce_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] wa,
  input  logic [7:0]        wd,
  input  logic [MEM_AW-1:0] ra,
  output logic [7:0]        rd
);
  logic [7:0] mem [MEM_DEP];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];
endmodule

// File: rtl/i2c_eeprom.sv
module i2c_eeprom
  import i2ce_pkg::*;
#(
  parameter int         FILT_CYC = 25,
  parameter int         WR_CYC   = 2500000,
  parameter logic [3:0] DEV_ID   = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o,
  input  logic wp_i
);
  logic [1:0]        rs;
  logic              rst_core_n;
  logic [1:0]        raw, flt;
  logic              scl_f, sda_f;
  logic              busy, pb_we, cm_go, cm_drop, mem_we;
  logic [7:0]        pb_dat, mem_dat, rd_dat;
  logic [MEM_AW-1:0] ptr, mem_addr;
  bus_st_t           bus_st;
  rx_kind_t          bus_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs <= 2'b00;
    else        rs <= {rs[0], 1'b1};
  end
  assign rst_core_n = rs[1];

  assign raw = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2ce_filt #(.CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_core_n), .din(raw[g]), .dout(flt[g])
    );
  end
  assign scl_f = flt[0];
  assign sda_f = flt[1];

  i2ce_bus #(.DEV_ID(DEV_ID)) u_bus (
    .clk(clk), .rst_n(rst_core_n), .scl_f(scl_f), .sda_f(sda_f),
    .busy(busy), .rd_dat(rd_dat), .sda_pull(sda_pull_o), .ptr(ptr),
    .pb_we(pb_we), .pb_dat(pb_dat), .cm_go(cm_go), .cm_drop(cm_drop),
    .st_o(bus_st), .kind_o(bus_kind)
  );

  i2ce_commit #(.WR_CYC(WR_CYC)) u_commit (
    .clk(clk), .rst_n(rst_core_n), .pb_we(pb_we), .pb_idx(ptr[PAGE_AW-1:0]),
    .pb_dat(pb_dat), .cm_go(cm_go), .cm_drop(cm_drop),
    .page(ptr[MEM_AW-1:PAGE_AW]), .wp(wp_i), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_dat(mem_dat)
  );

  i2ce_array u_array (
    .clk(clk), .we(mem_we), .wa(mem_addr), .wd(mem_dat), .ra(ptr), .rd(rd_dat)
  );
endmodule

// File: rtl/i2ce_chk.sv
module i2ce_chk
  import i2ce_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_f,
  input logic              sda_pull,
  input bus_st_t           st,
  input rx_kind_t          kind,
  input logic [MEM_AW-1:0] ptr,
  input logic              busy,
  input logic              cm_go,
  input logic              wp,
  input logic              pb_we
);
  a_r11_sda_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_f);

  a_r7_no_addr_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == S_ACK) |-> kind != K_ADDR);

  a_r6_wp_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_go && wp && !busy) |=> !busy);

  a_r4_page_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    pb_we |=> $stable(ptr[MEM_AW-1:PAGE_AW]));

  a_r3_tx_advances_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TACK && $past(st) == S_TX) |-> ptr == MEM_AW'($past(ptr) + MEM_AW'(1)));
endmodule

bind i2c_eeprom i2ce_chk u_chk (
  .clk(clk), .rst_n(rst_core_n), .scl_f(scl_f), .sda_pull(sda_pull_o),
  .st(bus_st), .kind(bus_kind), .ptr(ptr), .busy(busy), .cm_go(cm_go),
  .wp(wp_i), .pb_we(pb_we)
);

// File: tb/i2c_eeprom_test.sv
module i2c_eeprom_test;
  localparam int FILT = 4;
  localparam int WRC  = 3000;
  localparam int Q    = 20;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } item_t;

  logic clk, rst_n, scl_m, sda_m, wp, sda_pull;
  wire  sda_bus = sda_m & ~sda_pull;
  int   checks = 0, errors = 0;
  bit   done = 0;
  item_t      exp_q[$];
  logic [7:0] got_q[$];

  i2c_eeprom #(.FILT_CYC(FILT), .WR_CYC(WRC)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .wp_i(wp)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // scoreboard monitor: compares each received byte against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        logic [7:0] g;
        g = got_q.pop_front();
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL unexpected byte act=%h exp=none", g);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          if (g !== e.v) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", e.tag, g, e.v);
          end
        end
      end
    end
  end

  task automatic bstart();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  // glitch: 0 none, 1 short SCL dip, 2 short SDA dip (bit 5 must be 1)
  task automatic send_byte(input logic [7:0] b, input int glitch, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q);
      if (glitch == 1 && i == 5) begin
        scl_m = 1'b0; tick(2); scl_m = 1'b1; tick(Q - 2);
      end else if (glitch == 2 && i == 5) begin
        sda_m = 1'b0; tick(2); sda_m = 1'b1; tick(Q - 2);
      end else begin
        tick(Q);
      end
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_bus;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic last);
    logic [7:0] b;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q);
      b[i] = sda_bus;
      tick(Q); scl_m = 1'b0; tick(Q);
    end
    got_q.push_back(b);
    sda_m = last; tick(Q); scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  task automatic expect_bytes(input logic [7:0] first, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.v = first + 8'(i);
      it.tag = tag;
      exp_q.push_back(it);
    end
  endtask

  task automatic wr(input logic [2:0] blk, input logic [7:0] a, input int n,
                    input logic [7:0] v0, input string tag);
    logic ack;
    bstart();
    send_byte({4'b1010, blk, 1'b0}, 0, ack);
    chk({tag, " addr ack"}, ack, 1'b1);
    send_byte(a, 0, ack);
    for (int i = 0; i < n; i++) send_byte(v0 + 8'(i), 0, ack);
    chk({tag, " data ack"}, ack, 1'b1);
    bstop();
  endtask

  task automatic rd(input logic [2:0] blk, input logic [7:0] a, input int n,
                    input logic [7:0] e0, input int glitch, input string tag);
    logic ack;
    expect_bytes(e0, n, tag);
    bstart();
    send_byte({4'b1010, blk, 1'b0}, glitch, ack);
    chk({tag, " wr-addr ack"}, ack, 1'b1);
    send_byte(a, 0, ack);
    bstart();
    send_byte({4'b1010, blk, 1'b1}, 0, ack);
    chk({tag, " rd-addr ack"}, ack, 1'b1);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1);
    bstop();
  endtask

  task automatic poll(input logic [2:0] blk, output logic ack);
    bstart();
    send_byte({4'b1010, blk, 1'b0}, 0, ack);
    bstop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic ack;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0;
    tick(10);
    chk("R10 sda released in reset", sda_pull, 1'b0);
    rst_n = 1'b1;
    tick(20);
    chk("R10 sda released after reset", sda_pull, 1'b0);

    // R1: foreign device id is not acknowledged
    bstart();
    send_byte(8'h96, 0, ack);
    chk("R1 foreign id nack", ack, 1'b0);
    bstop();

    // R7/R1: page write, then poll during and after busy
    wr(3'd3, 8'h10, 8, 8'h40, "R1 write bank3");
    poll(3'd3, ack);
    chk("R7 busy nack", ack, 1'b0);
    tick(WRC + 50);
    poll(3'd3, ack);
    chk("R7 ack after busy", ack, 1'b1);

    wr(3'd5, 8'h10, 2, 8'h90, "R2 write bank5");
    tick(WRC + 50);

    // R2/R3/R8: read back four then NACK; continue with current-address read
    rd(3'd3, 8'h10, 4, 8'h40, 0, "R3 seq read bank3");
    expect_bytes(8'h44, 1, "R8 continue after nack");
    bstart();
    send_byte(8'hA7, 0, ack);
    chk("R8 current read ack", ack, 1'b1);
    recv_byte(1'b1);
    bstop();
    rd(3'd5, 8'h10, 1, 8'h90, 0, "R2 bank5 distinct");

    // R4: write wraps within page
    wr(3'd1, 8'h1E, 4, 8'h60, "R4 wrap write");
    tick(WRC + 50);
    rd(3'd1, 8'h00, 2, 8'h62, 0, "R4 wrapped to page start");
    rd(3'd1, 8'h1E, 2, 8'h60, 0, "R4 page tail");

    // R3: read pointer carries across bank boundary
    wr(3'd2, 8'hFE, 2, 8'h70, "R3 prep tail");
    tick(WRC + 50);
    wr(3'd3, 8'h00, 1, 8'h72, "R3 prep head");
    tick(WRC + 50);
    rd(3'd2, 8'hFE, 3, 8'h70, 0, "R3 cross bank");

    // R6: write protect vetoes commit, no busy
    wp = 1'b1;
    wr(3'd3, 8'h10, 2, 8'hEE, "R6 protected write");
    poll(3'd3, ack);
    chk("R6 no busy after vetoed write", ack, 1'b1);
    wp = 1'b0;
    rd(3'd3, 8'h10, 2, 8'h40, 0, "R6 array unchanged");

    // R5: repeated START discards staged data
    bstart();
    send_byte(8'hA6, 0, ack);
    send_byte(8'h12, 0, ack);
    send_byte(8'hDD, 0, ack);
    bstart();
    send_byte(8'hA6, 0, ack);
    chk("R5 no busy after discard", ack, 1'b1);
    bstop();
    rd(3'd3, 8'h12, 1, 8'h42, 0, "R5 array unchanged");

    // R9: spikes on SCL and SDA during address bytes
    rd(3'd3, 8'h00, 1, 8'h72, 1, "R9 scl spike");
    rd(3'd3, 8'h00, 1, 8'h72, 2, "R9 sda spike");

    tick(50);
    chk("R3 scoreboard drained", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule